// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This unit sits in front of a single-port word memory. It gives a processor indivisible read-modify-write access to that memory. One request port carries an operation code, a word address, a primary operand, a compare operand and a function select. The unit accepts a request, reads the addressed word, forms the new value and the return value from the old word and the operands, and writes the new value back where the operation calls for it. It then returns the result on a one-cycle response strobe.

Every request takes exactly two cycles: a read cycle and a write/respond cycle. The request port drops ready for the second cycle, so no other access can reach the memory between the read and the write of an operation. Plain reads and writes use the same two-cycle slot, which keeps the sequencing uniform.

The operation codes on `req_op_i` are: 0 read, 1 write, 2 swap, 3 test-and-set, 4 fetch-and-add, 5 compare-and-swap, 6 apply-function and 7 reserved. The function codes on `req_func_i` are: 0 increment, 1 decrement, 2 bitwise invert and 3 clear. A word is true when it is nonzero. The unit writes true as the value 1 and false as the value 0.

Top module: `amo_unit`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: A request is accepted in a cycle where `req_valid_i` and `req_ready_o` are both 1. In the next cycle `req_ready_o` is 0. In the cycle after that `rsp_valid_o` is 1 for exactly one cycle and `rsp_data_o` carries the result. Then `req_ready_o` is 1 again.
- R3: Read (op 0) returns the addressed word and leaves memory unchanged.
- R4: Write (op 1) stores `req_wdata_i` at the address and returns 0.
- R5: Swap (op 2) stores `req_wdata_i` and returns the word held before the store.
- R6: Test-and-set (op 3) on a word equal to 0 stores 1 and returns 0. On a nonzero word it leaves the word unchanged and returns 1.
- R7: Fetch-and-add (op 4) stores old + `req_wdata_i` modulo 2^32 and returns the old word.
- R8: Compare-and-swap (op 5) compares the word with `req_cmp_i`. If they are equal it stores `req_wdata_i` and returns 1. Otherwise it leaves memory unchanged and returns 0.
- R9: Apply-function (op 6) stores f(old), where `req_func_i` selects f: 0 = old+1, 1 = old−1, 2 = ~old, 3 = 0. Increment and decrement wrap modulo 2^32. It returns 0.
- R10: A memory write happens only in the cycle right after the read of the same address, within the same operation.
- R11: Reserved op 7 behaves as a read: it returns the word and leaves memory unchanged.
- R12: Requests presented while `req_ready_o` is 0 are ignored: they change no memory word and start no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Unit can accept a request |
| req_op_i | input | 3 | Operation code |
| req_addr_i | input | 8 | Word address |
| req_wdata_i | input | 32 | Store value, swap value, addend or new value for compare-and-swap |
| req_cmp_i | input | 32 | Expected value for compare-and-swap |
| req_func_i | input | 2 | Function select for apply-function |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_data_o | output | 32 | Operation result |

## Verification
Some properties are checked on every cycle. These are the handshake timing, the one-cycle response pulse, and the rule that a memory write follows directly on a read of the same address. The same cycle-by-cycle checks also cover the no-write cases of test-and-set on a true word, of a failed compare, and of read or reserved codes. The bench shows the actual values returned and stored: swap exchange, fetch-and-add wrap, each apply-function, and the outcome of each compare. It keeps a full model of the memory and ends with a complete read-back. Only the bench scenarios can show that a request held during the busy cycle leaves every word untouched.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_SWAP  = 3'd2,
    OP_TAS   = 3'd3,
    OP_FADD  = 3'd4,
    OP_CAS   = 3'd5,
    OP_RMW   = 3'd6,
    OP_RSVD  = 3'd7
  } amo_op_e;

  typedef enum logic [1:0] {
    FN_INC = 2'd0,
    FN_DEC = 2'd1,
    FN_NOT = 2'd2,
    FN_CLR = 2'd3
  } amo_fn_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } amo_st_e;
endpackage

// File: rtl/amo_mem.sv
module amo_mem #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              re_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // single port: write wins, rdata holds between reads
  always_ff @(posedge clk_i) begin
    if (we_i)      mem_q[addr_i] <= wdata_i;
    else if (re_i) rdata_o       <= mem_q[addr_i];
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  amo_op_e           op_i,
  input  amo_fn_e           fn_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [DATA_W-1:0] cmp_i,
  output logic [DATA_W-1:0] new_o,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_o
);
  localparam logic [DATA_W-1:0] W_TRUE  = DATA_W'(1);
  localparam logic [DATA_W-1:0] W_FALSE = '0;

  logic [DATA_W-1:0] fn_val;

  always_comb begin
    unique case (fn_i)
      FN_INC:  fn_val = old_i + W_TRUE;
      FN_DEC:  fn_val = old_i - W_TRUE;
      FN_NOT:  fn_val = ~old_i;
      default: fn_val = W_FALSE;
    endcase
  end

  always_comb begin
    new_o    = opnd_i;
    result_o = old_i;
    wr_o     = 1'b0;
    unique case (op_i)
      OP_WRITE: begin
        wr_o     = 1'b1;
        result_o = W_FALSE;
      end
      OP_SWAP: wr_o = 1'b1;
      OP_TAS: begin
        // true = any nonzero word
        wr_o     = (old_i == W_FALSE);
        new_o    = W_TRUE;
        result_o = (old_i == W_FALSE) ? W_FALSE : W_TRUE;
      end
      OP_FADD: begin
        wr_o  = 1'b1;
        new_o = old_i + opnd_i;
      end
      OP_CAS: begin
        wr_o     = (old_i == cmp_i);
        result_o = (old_i == cmp_i) ? W_TRUE : W_FALSE;
      end
      OP_RMW: begin
        wr_o     = 1'b1;
        new_o    = fn_val;
        result_o = W_FALSE;
      end
      default: ; // read and reserved: return old, no store
    endcase
  end
endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] req_cmp_i,
  input  logic [1:0]        req_func_i,
  // alu side
  output amo_op_e           op_o,
  output amo_fn_e           fn_o,
  output logic [DATA_W-1:0] opnd_o,
  output logic [DATA_W-1:0] cmp_o,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              wr_i,
  // memory side
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  // response
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  amo_st_e           state_q;
  amo_op_e           op_q;
  amo_fn_e           fn_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] opnd_q, cmp_q;
  logic              accept;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i & req_ready_o;

  // read in accept cycle, write (if any) in the following one
  assign mem_re_o    = accept;
  assign mem_we_o    = (state_q == ST_EXEC) & wr_i;
  assign mem_addr_o  = req_ready_o ? req_addr_i : addr_q;
  assign mem_wdata_o = new_i;

  assign op_o   = op_q;
  assign fn_o   = fn_q;
  assign opnd_o = opnd_q;
  assign cmp_o  = cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_READ;
      fn_q        <= FN_INC;
      addr_q      <= '0;
      opnd_q      <= '0;
      cmp_q       <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= (state_q == ST_EXEC);
      if (accept) begin
        state_q <= ST_EXEC;
        op_q    <= amo_op_e'(req_op_i);
        fn_q    <= amo_fn_e'(req_func_i);
        addr_q  <= req_addr_i;
        opnd_q  <= req_wdata_i;
        cmp_q   <= req_cmp_i;
      end else if (state_q == ST_EXEC) begin
        state_q    <= ST_IDLE;
        rsp_data_o <= result_i;
      end
    end
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);
  // R2
  rsp_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ##1 rsp_valid_o);
  // R2
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R10
  write_follows_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($past(mem_re_o) && (mem_addr_o == $past(mem_addr_o))));
  // R12
  no_accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC) |-> !mem_re_o);
  // R6
  tas_true_no_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && op_q == OP_TAS && old_i != '0) |-> !mem_we_o);
  // R8
  cas_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && op_q == OP_CAS) |-> (result_i[DATA_W-1:1] == '0 && mem_we_o == result_i[0]));
  // R3 R11
  read_no_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && (op_q == OP_READ || op_q == OP_RSVD)) |-> !mem_we_o);
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] req_cmp_i,
  input  logic [1:0]        req_func_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  amo_op_e           op;
  amo_fn_e           fn;
  logic [DATA_W-1:0] opnd, cmp, old_w, new_w, result;
  logic              wr, mem_re, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  amo_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_op_i    (req_op_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_cmp_i   (req_cmp_i),
    .req_func_i  (req_func_i),
    .op_o        (op),
    .fn_o        (fn),
    .opnd_o      (opnd),
    .cmp_o       (cmp),
    .old_i       (old_w),
    .new_i       (new_w),
    .result_i    (result),
    .wr_i        (wr),
    .mem_re_o    (mem_re),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o)
  );

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i     (op),
    .fn_i     (fn),
    .old_i    (old_w),
    .opnd_i   (opnd),
    .cmp_i    (cmp),
    .new_o    (new_w),
    .result_o (result),
    .wr_o     (wr)
  );

  amo_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk_i   (clk_i),
    .re_i    (mem_re),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (mem_wdata),
    .rdata_o (old_w)
  );
endmodule

// File: tb/sim_amo_unit.sv
`timescale 1ns/1ps
module sim_amo_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] req_cmp = '0;
  logic [1:0]  req_func = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] mdl [256];

  always #2.5 clk = ~clk;

  amo_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_cmp_i(req_cmp), .req_func_i(req_func),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [7:0] a, input logic [31:0] wd,
                        input logic [31:0] cm, input logic [1:0] fn, input bit junk,
                        output logic [31:0] res);
    @(negedge clk);
    chk(req_ready === 1'b1, "R2 ready idle", {31'd0, req_ready}, 32'd1);
    req_op = op; req_addr = a; req_wdata = wd; req_cmp = cm; req_func = fn;
    req_valid = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b0, "R2 busy", {31'd0, req_ready}, 32'd0);
    chk(rsp_valid === 1'b0, "R2 no early rsp", {31'd0, rsp_valid}, 32'd0);
    if (junk) begin
      // R12: conflicting request held while busy
      req_op = 3'd1; req_addr = a ^ 8'h01; req_wdata = 32'hBAD0_BAD0;
    end else begin
      req_valid = 1'b0;
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R2 rsp strobe", {31'd0, rsp_valid}, 32'd1);
    res = rsp_data;
  endtask

  task automatic exec_chk(input logic [2:0] op, input logic [7:0] a, input logic [31:0] wd,
                          input logic [31:0] cm, input logic [1:0] fn, input bit junk,
                          input string tag);
    logic [31:0] old, exp_res, exp_new, res;
    old = mdl[a];
    exp_new = old;
    exp_res = old;
    case (op)
      3'd1: begin exp_new = wd; exp_res = 32'd0; end
      3'd2: exp_new = wd;
      3'd3: if (old == 32'd0) begin exp_new = 32'd1; exp_res = 32'd0; end
            else exp_res = 32'd1;
      3'd4: exp_new = old + wd;
      3'd5: if (old == cm) begin exp_new = wd; exp_res = 32'd1; end
            else exp_res = 32'd0;
      3'd6: begin
        exp_res = 32'd0;
        case (fn)
          2'd0: exp_new = old + 32'd1;
          2'd1: exp_new = old - 32'd1;
          2'd2: exp_new = ~old;
          default: exp_new = 32'd0;
        endcase
      end
      default: ;
    endcase
    run_op(op, a, wd, cm, fn, junk, res);
    chk(res === exp_res, tag, res, exp_res);
    mdl[a] = exp_new;
  endtask

  function automatic logic [31:0] pat(input int a);
    return (32'(a) * 32'h0101_0101) ^ 32'h5A00_00C3;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(req_ready === 1'b1, "R1 ready in reset", {31'd0, req_ready}, 32'd1);
    chk(rsp_valid === 1'b0, "R1 rsp in reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", {31'd0, req_ready}, 32'd1);

    // R4 fill every word
    for (int a = 0; a < 256; a++) begin
      mdl[a] = 32'hxxxx_xxxx;
      exec_chk(3'd1, 8'(a), pat(a), 32'd0, 2'd0, 1'b0, "R4 write");
    end
    // R3 read back
    for (int a = 0; a < 256; a++) exec_chk(3'd0, 8'(a), 32'hFFFF_FFFF, 32'd0, 2'd3, 1'b0, "R3 read");

    // R5 swap
    for (int a = 0; a < 32; a++) begin
      exec_chk(3'd2, 8'(a), ~pat(a), 32'd0, 2'd0, 1'b0, "R5 swap old");
      exec_chk(3'd0, 8'(a), 32'd0, 32'd0, 2'd0, 1'b0, "R5 swap stored");
    end

    // R6 test-and-set
    exec_chk(3'd1, 8'd40, 32'd0, 32'd0, 2'd0, 1'b0, "R4 clear lock");
    exec_chk(3'd3, 8'd40, 32'd0, 32'd0, 2'd0, 1'b0, "R6 tas false");
    exec_chk(3'd3, 8'd40, 32'd0, 32'd0, 2'd0, 1'b0, "R6 tas true");
    exec_chk(3'd0, 8'd40, 32'd0, 32'd0, 2'd0, 1'b0, "R6 tas stored 1");
    exec_chk(3'd1, 8'd41, 32'hDEAD_0000, 32'd0, 2'd0, 1'b0, "R4 write");
    exec_chk(3'd3, 8'd41, 32'd0, 32'd0, 2'd0, 1'b0, "R6 tas nonzero");
    exec_chk(3'd0, 8'd41, 32'd0, 32'd0, 2'd0, 1'b0, "R6 tas unchanged");

    // R7 fetch-and-add, incl. wrap
    for (int a = 64; a < 96; a++) begin
      exec_chk(3'd4, 8'(a), 32'(a) * 32'h0123_4567, 32'd0, 2'd0, 1'b0, "R7 fadd");
      exec_chk(3'd0, 8'(a), 32'd0, 32'd0, 2'd0, 1'b0, "R7 fadd sum");
    end
    exec_chk(3'd1, 8'd100, 32'hFFFF_FFFF, 32'd0, 2'd0, 1'b0, "R4 write");
    exec_chk(3'd4, 8'd100, 32'd2, 32'd0, 2'd0, 1'b0, "R7 fadd wrap");
    exec_chk(3'd0, 8'd100, 32'd0, 32'd0, 2'd0, 1'b0, "R7 wrap result 1");

    // R8 compare-and-swap
    for (int a = 120; a < 136; a++) begin
      exec_chk(3'd5, 8'(a), 32'hC0DE_0000 | 32'(a), pat(a) ^ 32'd1, 2'd0, 1'b0, "R8 cas miss");
      exec_chk(3'd5, 8'(a), 32'hC0DE_0000 | 32'(a), pat(a), 2'd0, 1'b0, "R8 cas hit");
      exec_chk(3'd0, 8'(a), 32'd0, 32'd0, 2'd0, 1'b0, "R8 cas stored");
    end

    // R9 apply-function, all selects and wrap edges
    exec_chk(3'd1, 8'd150, 32'hFFFF_FFFF, 32'd0, 2'd0, 1'b0, "R4 write");
    exec_chk(3'd6, 8'd150, 32'd0, 32'd0, 2'd0, 1'b0, "R9 inc");
    exec_chk(3'd0, 8'd150, 32'd0, 32'd0, 2'd0, 1'b0, "R9 inc wraps to 0");
    exec_chk(3'd6, 8'd150, 32'd0, 32'd0, 2'd1, 1'b0, "R9 dec");
    exec_chk(3'd0, 8'd150, 32'd0, 32'd0, 2'd0, 1'b0, "R9 dec wraps");
    for (int a = 160; a < 176; a++) begin
      exec_chk(3'd6, 8'(a), 32'hFFFF_FFFF, 32'd0, 2'(a), 1'b0, "R9 fn");
      exec_chk(3'd0, 8'(a), 32'd0, 32'd0, 2'd0, 1'b0, "R9 fn stored");
    end

    // R11 reserved code
    exec_chk(3'd7, 8'd200, 32'h1234_5678, 32'h1234_5678, 2'd3, 1'b0, "R11 rsvd returns word");
    exec_chk(3'd0, 8'd200, 32'd0, 32'd0, 2'd0, 1'b0, "R11 rsvd unchanged");

    // R12 request held during busy cycle
    exec_chk(3'd4, 8'd10, 32'd5, 32'd0, 2'd0, 1'b1, "R12 fadd under junk");
    exec_chk(3'd0, 8'd11, 32'd0, 32'd0, 2'd0, 1'b0, "R12 neighbour untouched");
    exec_chk(3'd3, 8'd41, 32'd0, 32'd0, 2'd0, 1'b1, "R12 tas under junk");
    exec_chk(3'd0, 8'd40, 32'd0, 32'd0, 2'd0, 1'b0, "R12 neighbour untouched");

    // R10 full read-back against model
    for (int a = 0; a < 256; a++) exec_chk(3'd0, 8'(a), 32'd0, 32'd0, 2'd0, 1'b0, "R10 final image");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule